// File: doc/BRIEF.md
# Shared-Memory Byte Ring Agent

This block lets local logic push bytes into, and pull bytes from, a circular buffer that lives in the memory of a host processor. The host firmware works on the same buffer at the same time. The agent never owns the ring. It holds a local copy of the ring's geometry and of its own index. Every memory access goes through a bus-access port: raise a bus request, wait for the grant, do single-byte reads and writes, then let go of the bus.

Three control bytes sit directly below the data area. The byte at base-3 holds the length minus one, used as a mask. The byte at base-2 holds the producer index. The byte at base-1 holds the consumer index. Before each transfer the agent re-reads the other side's index from host memory, in a bus tenure of its own, to decide whether the ring is empty or full. When the ring is blocked it retries after a programmable idle gap. When it can proceed it moves the data byte and writes its own advanced index back, both inside a single tenure. A base address of zero means the agent is not initialised. In that state both status flags read 1 and get or put requests are dropped.

Top module: `shmRingAgent`

## Requirements
- R1: After reset the agent is idle: `busy`=0, `busReq`=0, `memReq`=0, `done`=0, and both `ringEmpty` and `ringFull` read 1 because the base is zero.
- R2: Init stores `initBase` and then, in one tenure, reads base-3 (mask), base-2 (producer index) and base-1 (consumer index), in that order. At the end `ringEmpty` = (producer == consumer) and `ringFull` = ((producer+1) AND mask == consumer).
- R3: While the stored base is zero, get and put requests cause no bus request, no memory access and no busy state.
- R4: A get first reads base-2 in a tenure of its own and treats the ring as empty when that value equals the local consumer index. While the ring is empty, `ringEmpty` is 1 and the poll repeats, with the bus request held low for at least POLL_GAP cycles between polls.
- R5: A non-empty get reads the byte at base + consumer index and writes (consumer+1) AND mask to base-1, in one tenure. That byte is on `rdData` in the cycle `done` is 1.
- R6: A put first reads base-1 in a tenure of its own and treats the ring as full when (local producer+1) AND mask equals that value. While the ring is full, `ringFull` is 1 and the poll repeats.
- R7: A non-full put writes the byte latched with the request to base + producer index, then writes (producer+1) AND mask to base-2, in one tenure.
- R8: Both indices wrap through the mask, so they run modulo the ring length (a power of two up to 256). An index that would reach the length becomes 0.
- R9: Bus protocol: `busReq` stays high until `busGnt` is seen. `memReq` is only high while both `busReq` and `busGnt` are high. A raised `memReq` and its address stay steady until `memAck`. After `busReq` drops, no new tenure starts until `busGnt` has fallen.
- R10: Requests are taken only while idle, with priority init, then get, then put. Other requests raised in the same cycle are dropped.
- R11: `done` is a single-cycle pulse that marks the end of every accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Start init with `initBase` |
| initBase | input | AW | Address of the ring's first data byte |
| getReq | input | 1 | Start a get |
| putReq | input | 1 | Start a put with `putData` |
| putData | input | 8 | Byte to enqueue, latched on acceptance |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte returned by the last get |
| ringEmpty | output | 1 | Last observed empty state, or base zero |
| ringFull | output | 1 | Last observed full state, or base zero |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus granted |
| memReq | output | 1 | Single-byte access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW | Access address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid with `memAck` |
| memAck | input | 1 | Access complete |

## Verification
Two things can land in the same cycle. The first is that get and put requests can be raised on the same clock edge. The bench provokes this with a ring that is not empty. It checks that only the get's accesses show up on the memory port, that the stored producer index in host memory is left alone, and that the returned byte is the one the model's queue predicts. The second collision is between init and get. There the access log must open with a read of base-3 and hold only the three descriptor reads. A third overlap is the host changing an index while the agent sits in its poll gap. The bench does this while a get is blocked on an empty ring, and while a put is blocked on a full one. It then checks that the next poll picks up the new index and finishes with the right byte and write-back.

// File: rtl/ringPkg.sv
package ringPkg;
  localparam int IW = 8;

  typedef enum logic [3:0] {
    K_MASK, K_INIT_IN, K_INIT_OUT, K_POLL_IN, K_POLL_OUT,
    K_RD_DATA, K_WR_OUT, K_WR_DATA, K_WR_IN
  } accKind_t;

  typedef enum logic [1:0] { OP_INIT, OP_GET, OP_PUT } opKind_t;

  typedef struct packed {
    logic     ldBase;
    logic     ldPut;
    logic     capture;
    accKind_t kind;
  } dpCtl_t;
endpackage

// File: rtl/ringData.sv
module ringData
  import ringPkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] initBase,
  input  logic [IW-1:0] putData,
  input  logic [IW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [IW-1:0] memWdata,
  output logic          baseZero,
  output logic          emptySeen,
  output logic          fullSeen,
  output logic [IW-1:0] getData
);
  logic [AW-1:0] baseQ;
  logic [IW-1:0] maskQ, inQ, outQ, putQ, getQ;
  logic          emptyQ, fullQ;
  logic [IW-1:0] nextIn, nextOut;

  assign nextIn   = (inQ + IW'(1)) & maskQ;
  assign nextOut  = (outQ + IW'(1)) & maskQ;
  assign baseZero = (baseQ == '0);
  assign emptySeen = emptyQ;
  assign fullSeen  = fullQ;
  assign getData   = getQ;

  always_comb begin
    unique case (ctl.kind)
      K_MASK:                         memAddr = baseQ - AW'(3);
      K_INIT_IN, K_POLL_IN, K_WR_IN:  memAddr = baseQ - AW'(2);
      K_INIT_OUT, K_POLL_OUT, K_WR_OUT: memAddr = baseQ - AW'(1);
      K_RD_DATA:                      memAddr = baseQ + AW'(outQ);
      K_WR_DATA:                      memAddr = baseQ + AW'(inQ);
      default:                        memAddr = baseQ;
    endcase
  end

  always_comb begin
    memWe    = (ctl.kind == K_WR_OUT) || (ctl.kind == K_WR_DATA) || (ctl.kind == K_WR_IN);
    memWdata = putQ;
    if (ctl.kind == K_WR_OUT) memWdata = nextOut;
    else if (ctl.kind == K_WR_IN) memWdata = nextIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      maskQ  <= '0;
      inQ    <= '0;
      outQ   <= '0;
      putQ   <= '0;
      getQ   <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b1;
    end else begin
      if (ctl.ldBase) baseQ <= initBase;
      if (ctl.ldPut)  putQ  <= putData;
      if (ctl.capture) begin
        unique case (ctl.kind)
          K_MASK:     maskQ <= memRdata;
          K_INIT_IN:  inQ   <= memRdata;
          K_INIT_OUT: begin
            outQ   <= memRdata;
            emptyQ <= (inQ == memRdata);
            fullQ  <= (nextIn == memRdata);
          end
          K_POLL_IN:  emptyQ <= (memRdata == outQ);
          K_POLL_OUT: fullQ  <= (nextIn == memRdata);
          K_RD_DATA:  getQ   <= memRdata;
          K_WR_OUT:   outQ   <= nextOut;
          K_WR_IN:    inQ    <= nextIn;
          default: ;
        endcase
      end
    end
  end

  // R8
  in_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.kind == K_WR_IN) |=> ((inQ & ~maskQ) == '0));

  // R5
  get_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.capture && ctl.kind == K_RD_DATA) |=> $stable(getQ));
endmodule

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringPkg::*;
#(
  parameter int POLL_GAP = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   initReq,
  input  logic   getReq,
  input  logic   putReq,
  input  logic   busGnt,
  input  logic   memAck,
  input  logic   baseZero,
  input  logic   emptySeen,
  input  logic   fullSeen,
  output dpCtl_t ctl,
  output logic   busReq,
  output logic   memReq,
  output logic   busy,
  output logic   done
);
  localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

  typedef enum logic [2:0] { S_IDLE, S_ACQ, S_XFER, S_REL, S_GAP } st_t;

  st_t      st;
  accKind_t kind, followKind;
  opKind_t  op;
  logic [GW-1:0] gapCnt;
  logic     doneQ, lastAcc, blocked;
  logic     startInit, startGet, startPut;

  always_comb begin
    startInit = (st == S_IDLE) && initReq;
    startGet  = (st == S_IDLE) && !initReq && getReq && !baseZero;
    startPut  = (st == S_IDLE) && !initReq && !getReq && putReq && !baseZero;
    blocked   = (op == OP_GET) ? emptySeen : fullSeen;
    lastAcc   = (kind == K_INIT_OUT) || (kind == K_POLL_IN) || (kind == K_POLL_OUT) ||
                (kind == K_WR_OUT) || (kind == K_WR_IN);
    unique case (kind)
      K_MASK:    followKind = K_INIT_IN;
      K_INIT_IN: followKind = K_INIT_OUT;
      K_RD_DATA: followKind = K_WR_OUT;
      K_WR_DATA: followKind = K_WR_IN;
      default:   followKind = kind;
    endcase
  end

  always_comb begin
    ctl.ldBase  = startInit;
    ctl.ldPut   = startPut;
    ctl.capture = (st == S_XFER) && memAck;
    ctl.kind    = kind;
  end

  assign busReq = (st == S_ACQ) || (st == S_XFER);
  assign memReq = (st == S_XFER);
  assign busy   = (st != S_IDLE);
  assign done   = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      kind   <= K_MASK;
      op     <= OP_INIT;
      gapCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (startInit) begin
            op <= OP_INIT; kind <= K_MASK; st <= S_ACQ;
          end else if (startGet) begin
            op <= OP_GET; kind <= K_POLL_IN; st <= S_ACQ;
          end else if (startPut) begin
            op <= OP_PUT; kind <= K_POLL_OUT; st <= S_ACQ;
          end
        end
        S_ACQ: if (busGnt) st <= S_XFER;
        S_XFER: begin
          if (memAck) begin
            if (lastAcc) st <= S_REL;
            else kind <= followKind;
          end
        end
        S_REL: begin
          if (!busGnt) begin
            if (kind == K_POLL_IN || kind == K_POLL_OUT) begin
              if (blocked) begin
                st     <= S_GAP;
                gapCnt <= GW'(POLL_GAP - 1);
              end else begin
                kind <= (kind == K_POLL_IN) ? K_RD_DATA : K_WR_DATA;
                st   <= S_ACQ;
              end
            end else begin
              st    <= S_IDLE;
              doneQ <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gapCnt == '0) begin
            st   <= S_ACQ;
            kind <= (op == OP_GET) ? K_POLL_IN : K_POLL_OUT;
          end else begin
            gapCnt <= gapCnt - GW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> busReq);

  // R9
  acc_in_tenure_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (busReq && busGnt));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(kind)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  unset_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !initReq && baseZero) |=> !busy);
endmodule

// File: rtl/shmRingAgent.sv
module shmRingAgent
  import ringPkg::*;
#(
  parameter int AW       = 16,
  parameter int POLL_GAP = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          initReq,
  input  logic [AW-1:0] initBase,
  input  logic          getReq,
  input  logic          putReq,
  input  logic [7:0]    putData,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdData,
  output logic          ringEmpty,
  output logic          ringFull,
  output logic          busReq,
  input  logic          busGnt,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdata,
  input  logic          memAck
);
  dpCtl_t ctl;
  logic   baseZero, emptySeen, fullSeen;

  ringCtrl #(.POLL_GAP(POLL_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .getReq(getReq), .putReq(putReq),
    .busGnt(busGnt), .memAck(memAck), .baseZero(baseZero),
    .emptySeen(emptySeen), .fullSeen(fullSeen), .ctl(ctl),
    .busReq(busReq), .memReq(memReq), .busy(busy), .done(done)
  );

  ringData #(.AW(AW)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .initBase(initBase), .putData(putData),
    .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .baseZero(baseZero), .emptySeen(emptySeen), .fullSeen(fullSeen), .getData(rdData)
  );

  assign ringEmpty = emptySeen || baseZero;
  assign ringFull  = fullSeen || baseZero;

  // R1
  unset_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && baseZero) |-> (ringEmpty && ringFull && !busReq));
endmodule

// File: tb/shmRingAgent_tb.sv
module shmRingAgent_tb;
  localparam int AW = 16;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, getReq = 1'b0, putReq = 1'b0;
  logic [AW-1:0] initBase = '0;
  logic [7:0] putData = '0;
  logic busy, done, ringEmpty, ringFull, busReq, memReq, memWe;
  logic [7:0] rdData, memWdata;
  logic [AW-1:0] memAddr;
  logic busGnt = 1'b0, memAck = 1'b0;
  logic [7:0] memRdata = '0;

  int nChecks = 0, nFails = 0;
  int tenures = 0, lowRun = 0, lastGap = 0;
  logic prevReq = 1'b0;
  logic [7:0] mem [int];
  int logQ[$];
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  shmRingAgent #(.AW(AW), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .initBase(initBase),
    .getReq(getReq), .putReq(putReq), .putData(putData), .busy(busy), .done(done),
    .rdData(rdData), .ringEmpty(ringEmpty), .ringFull(ringFull), .busReq(busReq),
    .busGnt(busGnt), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [7:0] rdMem(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic int enc(input bit we, input int a, input int d);
    return (int'(we) << 24) | ((a & 16'hFFFF) << 8) | (d & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // host memory and bus responder, plus per-cycle protocol model
  always @(negedge clk) begin
    if (rstN) begin
      chk(!memReq || (busReq && busGnt), "R9 access outside tenure", memReq, 0);
      if (busReq && !prevReq) begin
        tenures++;
        lastGap = lowRun;
        lowRun = 0;
      end
      if (!busReq) lowRun++;
    end
    prevReq = busReq;
    busGnt <= busReq;
    if (memAck) memAck <= 1'b0;
    else if (memReq) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[int'(memAddr)] = memWdata;
        logQ.push_back(enc(1'b1, int'(memAddr), int'(memWdata)));
      end else begin
        memRdata <= rdMem(int'(memAddr));
        logQ.push_back(enc(1'b0, int'(memAddr), int'(rdMem(int'(memAddr)))));
      end
    end
  end

  // which: 0 init, 1 get, 2 put, 3 get+put, 4 init+get
  task automatic runOp(input int which, input logic [AW-1:0] b, input logic [7:0] d,
                       output logic [7:0] got);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    initBase = b;
    putData  = d;
    initReq  = (which == 0) || (which == 4);
    getReq   = (which == 1) || (which == 3) || (which == 4);
    putReq   = (which == 2) || (which == 3);
    @(negedge clk);
    initReq = 1'b0; getReq = 1'b0; putReq = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, "R11 watchdog on operation", int'(seen), 1);
    got = rdData;
    @(negedge clk);
    chk(!done, "R11 done single pulse", int'(done), 0);
  endtask

  task automatic waitTenures(input int target);
    for (int i = 0; i < 4000 && tenures < target; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !busReq && !memReq && !done, "R1 idle after reset", int'(busy), 0);
    chk(ringEmpty && ringFull, "R1 flags with zero base", {ringEmpty, ringFull}, 3);

    // R3 requests ignored while base zero
    @(negedge clk); getReq = 1'b1; @(negedge clk); getReq = 1'b0; putReq = 1'b1;
    @(negedge clk); putReq = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy && tenures == 0 && logQ.size() == 0, "R3 no bus use when unset", tenures, 0);

    // R2 init
    mem[16'h0FFD] = 8'h07; mem[16'h0FFE] = 8'h02; mem[16'h0FFF] = 8'h02;
    logQ.delete(); t0 = tenures;
    runOp(0, 16'h1000, 8'h00, got);
    chk(logQ.size() == 3, "R2 three descriptor reads", logQ.size(), 3);
    if (logQ.size() == 3) begin
      chk(logQ[0] == enc(0, 16'h0FFD, 7), "R2 mask read first", logQ[0], enc(0, 16'h0FFD, 7));
      chk(logQ[2] == enc(0, 16'h0FFF, 2), "R2 consumer read last", logQ[2], enc(0, 16'h0FFF, 2));
    end
    chk(tenures - t0 == 1, "R2 single tenure", tenures - t0, 1);
    chk(ringEmpty && !ringFull, "R2 flags after init", {ringEmpty, ringFull}, 2);

    // R7 put into free ring
    logQ.delete(); t0 = tenures;
    runOp(2, '0, 8'hA5, got); expQ.push_back(8'hA5);
    chk(logQ.size() == 3 && logQ[0] == enc(0, 16'h0FFF, 2), "R6 poll reads consumer index",
        logQ.size(), 3);
    chk(rdMem(16'h1002) == 8'hA5, "R7 data byte at base+producer", rdMem(16'h1002), 8'hA5);
    chk(rdMem(16'h0FFE) == 8'h03, "R7 producer index written back", rdMem(16'h0FFE), 3);
    chk(tenures - t0 == 2, "R7 poll and transfer tenures", tenures - t0, 2);

    // R5 get from non-empty ring
    logQ.delete();
    runOp(1, '0, 8'h00, got);
    chk(got == expQ.pop_front(), "R5 returned byte", got, 8'hA5);
    chk(rdMem(16'h0FFF) == 8'h03, "R5 consumer index written back", rdMem(16'h0FFF), 3);
    chk(logQ.size() == 3 && logQ[1] == enc(0, 16'h1002, 8'hA5), "R5 data read address",
        logQ.size(), 3);
    chk(!ringEmpty, "R4 not empty after successful poll", int'(ringEmpty), 0);

    // R4 get blocked on empty ring until host produces
    t0 = tenures;
    fork
      runOp(1, '0, 8'h00, got);
      begin
        waitTenures(t0 + 3);
        chk(ringEmpty && busy, "R4 empty while polling", int'(ringEmpty), 1);
        chk(lastGap >= GAP, "R4 idle gap between polls", lastGap, GAP);
        mem[16'h1003] = 8'h5A;
        mem[16'h0FFE] = 8'h04;
      end
    join
    chk(got == 8'h5A, "R4 byte after host produced", got, 8'h5A);
    chk(rdMem(16'h0FFF) == 8'h04, "R5 consumer index after wait", rdMem(16'h0FFF), 4);

    // R8 fill a ring that starts near the top, wrapping the producer
    mem[16'h1FFD] = 8'h07; mem[16'h1FFE] = 8'h06; mem[16'h1FFF] = 8'h06;
    runOp(0, 16'h2000, 8'h00, got);
    for (int i = 0; i < 7; i++) begin
      runOp(2, '0, 8'(8'h10 + i), got);
      if (i == 1) chk(rdMem(16'h1FFE) == 8'h00, "R8 producer wraps to zero", rdMem(16'h1FFE), 0);
    end
    chk(rdMem(16'h1FFE) == 8'h05, "R7 producer after seven puts", rdMem(16'h1FFE), 5);

    // R6 eighth put blocks until host consumes
    t0 = tenures;
    fork
      runOp(2, '0, 8'h17, got);
      begin
        waitTenures(t0 + 3);
        chk(ringFull && busy, "R6 full while polling", int'(ringFull), 1);
        chk(rdMem(16'h2005) == 8'h00, "R6 no data write while full", rdMem(16'h2005), 0);
        mem[16'h1FFF] = 8'h07;
      end
    join
    for (int i = 0; i < 8; i++)
      chk(rdMem(16'h2000 + ((6 + i) & 7)) == 8'(8'h10 + i), "R8 wrapped data placement",
          rdMem(16'h2000 + ((6 + i) & 7)), 8'h10 + i);
    chk(rdMem(16'h1FFE) == 8'h06, "R7 producer after blocked put", rdMem(16'h1FFE), 6);

    // R2 re-init reads a full ring
    runOp(0, 16'h2000, 8'h00, got);
    chk(!ringEmpty && ringFull, "R2 full flag at init", {ringEmpty, ringFull}, 1);

    // R10 get and put in same cycle: get wins, put dropped
    logQ.delete(); t0 = tenures;
    runOp(3, '0, 8'hEE, got);
    repeat (8) @(negedge clk);
    chk(got == 8'h11, "R10 get served", got, 8'h11);
    chk(rdMem(16'h1FFF) == 8'h00, "R8 consumer wraps to zero", rdMem(16'h1FFF), 0);
    chk(logQ.size() == 3 && tenures - t0 == 2 && rdMem(16'h1FFE) == 8'h06,
        "R10 put dropped", logQ.size(), 3);

    // R10 init and get together: init wins
    mem[16'h2FFD] = 8'h03; mem[16'h2FFE] = 8'h03; mem[16'h2FFF] = 8'h00;
    logQ.delete();
    runOp(4, 16'h3000, 8'h00, got);
    repeat (8) @(negedge clk);
    chk(logQ.size() == 3 && logQ[0] == enc(0, 16'h2FFD, 3), "R10 init has priority",
        logQ.size(), 3);
    chk(!ringEmpty && ringFull, "R2 full with short ring", {ringEmpty, ringFull}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule